// File: doc/BRIEF.md
# Memory Access Permission Checker

This block screens every memory access before it reaches the load/store path or the instruction fetch path. Each access carries an address, a kind (load, store or fetch), an alignment mask and a machine profile selector. The block returns the address with its low bits forced to the required alignment where the profile calls for that. It also returns at most one fault code for the access. Three profiles are supported. Each one has its own forbidden address windows and its own way of treating misalignment. Two control inputs change the outcome: one suppresses alignment faults on the first profile, and one opens a small configuration window on the second and third profiles.

Results are registered one cycle behind a valid/ready handshake. A one-cycle fault strobe marks the first cycle in which a faulting result is shown. Interrupt queueing, caches and memory are handled elsewhere.

Encodings used throughout. Kind: 0 load, 1 store, 2 fetch, 3 reserved. Profile: 0 = A, 1 = B, 2 = C, 3 reserved. Fault code: 0 none, 1 misaligned, 2 data access error, 3 data access exception, 4 instruction access error, 5 instruction access exception, 6 data store error. The mask takes the values 0, 1, 3, 7 and 15. An access is misaligned when `addr[3:0] & mask` is nonzero.

Top module: `perm_checker`

## Requirements
- R1: An access accepted while `req_valid` and `req_ready` are high appears on `rsp_*` and `flt_code` in the next cycle. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the result is held unchanged.
- R2: `flt_valid` is high only in the first cycle a result is shown, and only when its code is nonzero. Codes follow the encoding above, and one code is reported per access.
- R3: On profiles A and B (any non-reserved kind), and for fetches on profile C, `rsp_addr` is the request address with the mask bits cleared. Profile C loads and stores pass the address unchanged.
- R4: On profile A, a misaligned load or store gives code 2 unless `ctl_align_mask_exc` is set.
- R5: On profile A, a load with mask 7 in 0xFE800000–0xFEFFFFFF gives code 2. Other masks and stores do not trigger this check.
- R6: On profile A, a fetch that is misaligned or in 0xFE800000–0xFEFFFFFF gives code 4.
- R7: On profile B, a misaligned load, store or fetch gives code 1, and this outranks every other fault.
- R8: On profile B, an aligned access in 0xFEFF0600–0xFEFF7FFF or 0xFE800000–0xFEFEFFFF gives code 2 for a load, code 6 for a store and code 4 for a fetch.
- R9: On profile B, an aligned load or store in 0xFE000000–0xFE7FFFFF gives code 3.
- R10: On profile B, a fetch in 0xFE004000–0xFE7FFFFF gives code 5. A fetch in 0xFE000000–0xFE003FFF gives code 5 only when `ctl_region_en` is clear.
- R11: On profile C there is no alignment fault. A load in 0xFE800000–0xFEFEFFFF gives code 2, and a store there gives code 6. Otherwise a load or store in 0xFE000000–0xFE7FFFFF gives code 3, except in 0xFE400000–0xFE407FFF while `ctl_region_en` is set.
- R12: On profile C, a fetch in 0xFE800000–0xFEFFFFFF gives code 4. A fetch in 0xFE008000–0xFE7FFFFF gives code 5. A fetch in 0xFE000000–0xFE007FFF gives code 5 only when `ctl_region_en` is clear.
- R13: A reserved profile or a reserved kind gives code 0 and leaves the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Access address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| req_mask | input | MASK_W | Alignment mask (0, 1, 3, 7, 15) |
| req_profile | input | 2 | Machine profile A/B/C/reserved |
| ctl_align_mask_exc | input | 1 | Suppresses alignment faults on profile A |
| ctl_region_en | input | 1 | Opens the configuration window on profiles B and C |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumed |
| rsp_addr | output | ADDR_W | Corrected address |
| flt_valid | output | 1 | One-cycle fault strobe |
| flt_code | output | 3 | Fault code of the shown result |

## Verification
The assertions assume that the mask is one of the five legal values. They also assume that request fields are stable only when sampled at the clock edge, and that `rsp_ready` can be dropped at any time. The stimulus drives only legal masks, and it changes inputs away from the rising edge. One phase drops `rsp_ready` while a faulting result is shown, and another streams one access per cycle. The sweep crosses every region edge with small offsets, all profiles and kinds, every mask and both control bits. This covers both sides of every window boundary and every priority overlap.

// File: rtl/perm_chk_pkg.sv
package perm_chk_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSV   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        PROF_A   = 2'd0,
        PROF_B   = 2'd1,
        PROF_C   = 2'd2,
        PROF_RSV = 2'd3
    } prof_e;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_MISALIGN = 3'd1,
        FLT_DERR     = 3'd2,
        FLT_DEXC     = 3'd3,
        FLT_IERR     = 3'd4,
        FLT_IEXC     = 3'd5,
        FLT_STORE    = 3'd6
    } flt_e;

    // Address windows used by the rule logic
    localparam int NUM_RG    = 7;
    localparam int RG_HI_ALL = 0;   // upper half of the protected space
    localparam int RG_HI_LOW = 1;   // upper half minus its top 64 KiB
    localparam int RG_IOWIN  = 2;   // small window inside the top 64 KiB
    localparam int RG_LO_ALL = 3;   // lower half of the protected space
    localparam int RG_B_CFG  = 4;   // profile B fetch config window
    localparam int RG_C_DCFG = 5;   // profile C data config window
    localparam int RG_C_ICFG = 6;   // profile C fetch config window

    localparam logic [31:0] RG_LO [NUM_RG] = '{
        32'hFE80_0000, 32'hFE80_0000, 32'hFEFF_0600, 32'hFE00_0000,
        32'hFE00_0000, 32'hFE40_0000, 32'hFE00_0000
    };
    localparam logic [31:0] RG_HI [NUM_RG] = '{
        32'hFEFF_FFFF, 32'hFEFE_FFFF, 32'hFEFF_7FFF, 32'hFE7F_FFFF,
        32'hFE00_3FFF, 32'hFE40_7FFF, 32'hFE00_7FFF
    };

endpackage

// File: rtl/perm_region_decode.sv
module perm_region_decode
    import perm_chk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_RG-1:0] hits
);
    for (genvar i = 0; i < NUM_RG; i++) begin : g_rg
        localparam logic [ADDR_W-1:0] LO = ADDR_W'(RG_LO[i]);
        localparam logic [ADDR_W-1:0] HI = ADDR_W'(RG_HI[i]);
        assign hits[i] = (addr >= LO) && (addr <= HI);
    end
endmodule

// File: rtl/perm_align.sv
module perm_align #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [MASK_W-1:0] mask,
    input  logic              apply,
    output logic              misal,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int PAD_W = ADDR_W - MASK_W;

    logic [ADDR_W-1:0] cleared;

    always_comb begin
        misal    = |(addr[MASK_W-1:0] & mask);
        cleared  = addr & ~{{PAD_W{1'b0}}, mask};
        addr_out = apply ? cleared : addr;
    end
endmodule

// File: rtl/perm_rules.sv
module perm_rules
    import perm_chk_pkg::*;
#(
    parameter int MASK_W = 4
) (
    input  prof_e             prof,
    input  acc_kind_e         kind,
    input  logic [MASK_W-1:0] mask,
    input  logic [NUM_RG-1:0] hits,
    input  logic              misal,
    input  logic              align_exc_off,
    input  logic              region_en,
    output logic              do_align,
    output flt_e              code
);
    localparam logic [MASK_W-1:0] DW_MASK = MASK_W'(7);

    logic is_data;
    logic err_win_b;
    logic exc_b_fetch;
    logic exc_c_data;
    logic exc_c_fetch;

    always_comb begin
        is_data     = (kind == ACC_LOAD) || (kind == ACC_STORE);
        err_win_b   = hits[RG_IOWIN] || hits[RG_HI_LOW];
        exc_b_fetch = hits[RG_LO_ALL] && !(hits[RG_B_CFG] && region_en);
        exc_c_data  = hits[RG_LO_ALL] && !(hits[RG_C_DCFG] && region_en);
        exc_c_fetch = hits[RG_LO_ALL] && !(hits[RG_C_ICFG] && region_en);
        do_align    = 1'b0;
        code        = FLT_NONE;

        unique case (prof)
            PROF_A: begin
                do_align = (kind != ACC_RSV);
                if (kind == ACC_FETCH) begin
                    if (misal || hits[RG_HI_ALL]) code = FLT_IERR;
                end else if (is_data) begin
                    if ((misal && !align_exc_off) ||
                        (kind == ACC_LOAD && mask == DW_MASK && hits[RG_HI_ALL]))
                        code = FLT_DERR;
                end
            end
            PROF_B: begin
                do_align = (kind != ACC_RSV);
                if (kind != ACC_RSV && misal) begin
                    code = FLT_MISALIGN;
                end else begin
                    unique case (kind)
                        ACC_LOAD:  code = err_win_b ? FLT_DERR
                                        : (hits[RG_LO_ALL] ? FLT_DEXC : FLT_NONE);
                        ACC_STORE: code = err_win_b ? FLT_STORE
                                        : (hits[RG_LO_ALL] ? FLT_DEXC : FLT_NONE);
                        ACC_FETCH: code = err_win_b ? FLT_IERR
                                        : (exc_b_fetch ? FLT_IEXC : FLT_NONE);
                        default:   code = FLT_NONE;
                    endcase
                end
            end
            PROF_C: begin
                do_align = (kind == ACC_FETCH);
                unique case (kind)
                    ACC_LOAD:  code = hits[RG_HI_LOW] ? FLT_DERR
                                    : (exc_c_data ? FLT_DEXC : FLT_NONE);
                    ACC_STORE: code = hits[RG_HI_LOW] ? FLT_STORE
                                    : (exc_c_data ? FLT_DEXC : FLT_NONE);
                    ACC_FETCH: code = hits[RG_HI_ALL] ? FLT_IERR
                                    : (exc_c_fetch ? FLT_IEXC : FLT_NONE);
                    default:   code = FLT_NONE;
                endcase
            end
            default: begin
                do_align = 1'b0;
                code     = FLT_NONE;
            end
        endcase
    end
endmodule

// File: rtl/perm_checker.sv
module perm_checker
    import perm_chk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic [MASK_W-1:0] req_mask,
    input  logic [1:0]        req_profile,
    input  logic              ctl_align_mask_exc,
    input  logic              ctl_region_en,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              flt_valid,
    output logic [2:0]        flt_code
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        flt_e              code;
        logic              pulse;
    } stage_t;

    stage_t st_d, st_q;

    logic [NUM_RG-1:0] hits;
    logic              misal;
    logic              do_align;
    logic [ADDR_W-1:0] fixed_addr;
    flt_e              code;
    logic              accept;

    perm_region_decode #(.ADDR_W(ADDR_W)) u_region (
        .addr (req_addr),
        .hits (hits)
    );

    perm_align #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_align (
        .addr     (req_addr),
        .mask     (req_mask),
        .apply    (do_align),
        .misal    (misal),
        .addr_out (fixed_addr)
    );

    perm_rules #(.MASK_W(MASK_W)) u_rules (
        .prof          (prof_e'(req_profile)),
        .kind          (acc_kind_e'(req_kind)),
        .mask          (req_mask),
        .hits          (hits),
        .misal         (misal),
        .align_exc_off (ctl_align_mask_exc),
        .region_en     (ctl_region_en),
        .do_align      (do_align),
        .code          (code)
    );

    always_comb begin
        req_ready = !st_q.vld || rsp_ready;
        accept    = req_valid && req_ready;
        st_d      = st_q;
        st_d.pulse = 1'b0;
        if (accept) begin
            st_d.vld   = 1'b1;
            st_d.addr  = fixed_addr;
            st_d.code  = code;
            st_d.pulse = (code != FLT_NONE);
        end else if (rsp_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, addr: '0, code: FLT_NONE, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.vld;
    assign rsp_addr  = st_q.addr;
    assign flt_valid = st_q.pulse;
    assign flt_code  = st_q.code;

endmodule

// File: rtl/perm_checker_sva.sv
module perm_checker_sva #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_kind,
    input logic [MASK_W-1:0] req_mask,
    input logic [1:0]        req_profile,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              flt_valid,
    input logic [2:0]        flt_code
);
    logic take;
    assign take = req_valid && req_ready;

    assert_accept_shows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> rsp_valid);

    assert_hold_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(flt_code)));

    assert_strobe_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> !flt_valid);

    assert_strobe_has_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> (rsp_valid && flt_code != 3'd0));

    assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (flt_code <= 3'd6));

    assert_b_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_profile == 2'd1 && req_kind != 2'd3)
        |=> ((rsp_addr[MASK_W-1:0] & $past(req_mask)) == '0));

    assert_c_data_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_profile == 2'd2 && req_kind[1] == 1'b0)
        |=> (rsp_addr == $past(req_addr) && flt_code != 3'd1));

    assert_reserved_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (req_profile == 2'd3 || req_kind == 2'd3))
        |=> (flt_code == 3'd0 && rsp_addr == $past(req_addr)));

endmodule

bind perm_checker perm_checker_sva #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_kind    (req_kind),
    .req_mask    (req_mask),
    .req_profile (req_profile),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_addr    (rsp_addr),
    .flt_valid   (flt_valid),
    .flt_code    (flt_code)
);

// File: tb/sim_perm_checker.sv
`timescale 1ns/1ps
module sim_perm_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic [3:0]  req_mask = '0;
    logic [1:0]  req_profile = '0;
    logic        ctl_align_mask_exc = 1'b0;
    logic        ctl_region_en = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_addr;
    logic        flt_valid;
    logic [2:0]  flt_code;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    perm_checker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_kind(req_kind), .req_mask(req_mask),
        .req_profile(req_profile), .ctl_align_mask_exc(ctl_align_mask_exc),
        .ctl_region_en(ctl_region_en), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_addr(rsp_addr), .flt_valid(flt_valid), .flt_code(flt_code)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic bit inr(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    // Independent model of the requirement text
    function automatic void model(input logic [31:0] a, input logic [1:0] k, input logic [3:0] m,
                                  input logic [1:0] p, input bit mae, input bit rme,
                                  output logic [31:0] ea, output logic [2:0] ec);
        bit mis   = (a[3:0] & m) != 4'd0;
        bit lo    = inr(a, 32'hFE00_0000, 32'hFE7F_FFFF);
        bit hiall = inr(a, 32'hFE80_0000, 32'hFEFF_FFFF);
        bit hilow = inr(a, 32'hFE80_0000, 32'hFEFE_FFFF);
        bit io    = inr(a, 32'hFEFF_0600, 32'hFEFF_7FFF);
        logic [31:0] al = a & ~{28'd0, m};
        ea = a;
        ec = 3'd0;
        if (k == 2'd3 || p == 2'd3) return;                 // R13
        if (p == 2'd0) begin                                 // R4 R5 R6
            ea = al;
            if (k == 2'd2) begin
                if (mis || hiall) ec = 3'd4;
            end else if ((mis && !mae) || (k == 2'd0 && m == 4'd7 && hiall)) ec = 3'd2;
        end else if (p == 2'd1) begin                        // R7 R8 R9 R10
            ea = al;
            if (mis) ec = 3'd1;
            else if (io || hilow) ec = (k == 2'd0) ? 3'd2 : (k == 2'd1) ? 3'd6 : 3'd4;
            else if (lo) begin
                if (k != 2'd2) ec = 3'd3;
                else if (!(rme && inr(a, 32'hFE00_0000, 32'hFE00_3FFF))) ec = 3'd5;
            end
        end else begin                                       // R11 R12
            if (k == 2'd2) begin
                ea = al;
                if (hiall) ec = 3'd4;
                else if (lo && !(rme && inr(a, 32'hFE00_0000, 32'hFE00_7FFF))) ec = 3'd5;
            end else begin
                if (hilow) ec = (k == 2'd0) ? 3'd2 : 3'd6;
                else if (lo && !(rme && inr(a, 32'hFE40_0000, 32'hFE40_7FFF))) ec = 3'd3;
            end
        end
    endfunction

    function automatic string tag(input logic [1:0] p, input logic [1:0] k);
        if (p == 2'd3 || k == 2'd3) return "R13 R3";
        if (p == 2'd0) return (k == 2'd2) ? "R6 R3" : "R4 R5 R3";
        if (p == 2'd1) return (k == 2'd2) ? "R7 R10 R3" : "R7 R8 R9 R3";
        return (k == 2'd2) ? "R12 R3" : "R11 R3";
    endfunction

    localparam int NB = 12;
    localparam int ND = 8;
    localparam logic [31:0] BASES [NB] = '{
        32'hFE00_0000, 32'hFE00_4000, 32'hFE00_8000, 32'hFE40_0000,
        32'hFE40_4000, 32'hFE40_8000, 32'hFE80_0000, 32'hFEFF_0000,
        32'hFEFF_0600, 32'hFEFF_8000, 32'hFF00_0000, 32'h0000_1000
    };
    localparam logic [31:0] DELTAS [ND] = '{
        32'd0, 32'd1, 32'd2, 32'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'hFFFF_FFF8, 32'd12
    };

    logic [31:0] ea;
    logic [2:0]  ec;

    initial begin
        // reset state (R1)
        repeat (3) @(negedge clk);
        check("R1 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R2 reset flt_valid", {63'd0, flt_valid}, 64'd0);
        check("R1 reset req_ready", {63'd0, req_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // stall: profile B misaligned load, consumer not ready
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_profile = 2'd1; req_kind = 2'd0;
        req_mask = 4'd3; req_addr = 32'hFE00_0001;
        @(negedge clk);
        check("R1 shown next cycle", {63'd0, rsp_valid}, 64'd1);
        check("R7 misaligned code", {61'd0, flt_code}, 64'd1);
        check("R3 aligned addr", {32'd0, rsp_addr}, 64'hFE00_0000);
        check("R2 strobe first cycle", {63'd0, flt_valid}, 64'd1);
        check("R1 not ready while stalled", {63'd0, req_ready}, 64'd0);
        req_profile = 2'd2; req_kind = 2'd2; req_addr = 32'hFE90_0002;
        @(negedge clk);
        check("R2 strobe only once", {63'd0, flt_valid}, 64'd0);
        check("R1 held addr", {32'd0, rsp_addr}, 64'hFE00_0000);
        check("R1 held code", {61'd0, flt_code}, 64'd1);
        rsp_ready = 1'b1;
        @(negedge clk);
        check("R12 fetch error code", {61'd0, flt_code}, 64'd4);
        check("R3 fetch addr aligned", {32'd0, rsp_addr}, 64'hFE90_0000);
        check("R2 strobe for new access", {63'd0, flt_valid}, 64'd1);
        req_valid = 1'b0;
        @(negedge clk);
        check("R1 drained", {63'd0, rsp_valid}, 64'd0);

        // sweep: one access per cycle
        req_valid = 1'b1;
        for (int b = 0; b < NB; b++) begin
            for (int d = 0; d < ND; d++) begin
                for (int p = 0; p < 4; p++) begin
                    for (int k = 0; k < 4; k++) begin
                        for (int mi = 0; mi < 5; mi++) begin
                            for (int f = 0; f < 4; f++) begin
                                logic [3:0] mv;
                                mv = (mi == 4) ? 4'd15 : 4'((1 << mi) - 1);
                                req_addr = BASES[b] + DELTAS[d];
                                req_profile = 2'(p);
                                req_kind = 2'(k);
                                req_mask = mv;
                                ctl_align_mask_exc = f[0];
                                ctl_region_en = f[1];
                                model(req_addr, req_kind, mv, req_profile, f[0], f[1], ea, ec);
                                @(negedge clk);
                                check({tag(2'(p), 2'(k)), " code/addr"},
                                      {29'd0, flt_code, rsp_addr}, {29'd0, ec, ea});
                                check("R2 strobe", {63'd0, flt_valid}, {63'd0, ec != 3'd0});
                            end
                        end
                    end
                end
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule